// File: doc/BRIEF.md
# Conditional Skip Evaluator

This block decodes a skip-group instruction and decides whether the program counter must step over the next word. It looks at the 18-bit instruction word, the accumulator, the I/O register, the overflow flag, six sense switches and six program flags. From these it produces a skip request and a strobe that clears the overflow flag. A single instruction can select several conditions. The selected conditions are ORed together, and one invert bit in the opcode turns each "skip if" into "skip if not".

The instruction word has a fixed layout. Bits 17:12 hold the opcode: octal 64 means skip-if and octal 65 means skip-if-not, so bit 12 is the invert bit. The condition mask sits in the low twelve bits. The two three-bit selector fields, one for a sense switch and one for a program flag, also sit in the low bits. Both outputs are registered. The decision for an instruction presented at one rising edge appears after that edge, however many conditions the instruction combines. The surrounding sequencer adds one to the program counter when `skip_req` is high, and it clears its overflow flip-flop when `ovf_clear` is high.

Top module: `skip_eval`

## Requirements
- R1: While `rst_n` is low at a rising edge, both `skip_req` and `ovf_clear` are 0 after that edge.
- R2: When `instr[17:12]` is neither octal 64 nor octal 65, both outputs are 0 after the edge, whatever the other inputs are.
- R3: The outputs are registered. They reflect only the inputs sampled at the last rising edge, and input changes between edges do not affect them.
- R4: Mask bit 6 (octal 0100) selects "accumulator is zero". In ones' complement, only the all-zeros word counts as zero, so the all-ones word (minus zero) fails this test.
- R5: Mask bit 7 (octal 0200) selects "accumulator positive" (`acc[17]` = 0). Mask bit 8 (octal 0400) selects "accumulator minus" (`acc[17]` = 1).
- R6: Mask bit 9 (octal 1000) selects "overflow is zero". Any skip instruction with this bit set drives `ovf_clear` to 1 after the edge, whatever the skip outcome.
- R7: Mask bit 10 (octal 2000) selects "I/O register positive" (`io_reg[17]` = 0).
- R8: The sense-switch field `instr[5:3]` works as follows. A value of 1 to 6 selects the test "switch N-1 of `sense_sw` is 0". A value of 7 selects the test "all switches are 0". A value of 0 selects no test.
- R9: The program-flag field `instr[2:0]` works the same way on `prog_flag`. A value of 1 to 6 tests "flag N-1 is 0", a value of 7 tests "all flags are 0", and a value of 0 selects no test.
- R10: The selected conditions are ORed, and the result is XORed with the invert bit `instr[12]`. An instruction with the invert bit set and no condition selected therefore always skips.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 18 | Instruction word under evaluation |
| acc | input | 18 | Accumulator, ones' complement |
| io_reg | input | 18 | I/O register |
| ovf | input | 1 | Overflow flag |
| sense_sw | input | 6 | Sense switch levels |
| prog_flag | input | 6 | Program flag levels |
| skip_req | output | 1 | Request to skip the next word |
| ovf_clear | output | 1 | Strobe that clears the overflow flag |

## Verification
The bench builds the block with its default parameters: six switches, six flags and three-bit selector fields. With these values every selector code is meaningful. Codes 1 through 6 each reach a real line, code 7 reaches the all-lines test, and code 0 reaches the no-test case. The bench can therefore check each switch and flag position, including the highest one, and it covers the invert-with-empty-mask case. It can also hold ones' complement minus zero against the zero and sign tests.

// File: rtl/skip_eval_pkg.sv
// Package: shared constants and the decoded-instruction type for the skip
// evaluator. Assumes the fixed 18-bit instruction layout: opcode in bits
// 17:12 (bit 12 = invert), condition mask bits 10:6, selectors 5:3 and 2:0.
package skip_eval_pkg;

    localparam int WORD_W    = 18;
    localparam int OP_HI     = 17;
    localparam int OP_LO     = 13;
    localparam int INV_BIT   = 12;
    localparam int SPARE_BIT = 11;
    localparam int IOSGN_BIT = 10;
    localparam int OVF_BIT   = 9;
    localparam int MINUS_BIT = 8;
    localparam int PLUS_BIT  = 7;
    localparam int ZERO_BIT  = 6;
    localparam int SEL_W     = 3;
    localparam int SW_LO     = 3;
    localparam int FLG_LO    = 0;

    // Upper five opcode bits shared by the skip-if and skip-if-not forms.
    localparam logic [OP_HI-OP_LO:0] SKIP_OP = 5'b11010;

    typedef struct packed {
        logic             is_skip;
        logic             invert;
        logic             t_zero;
        logic             t_plus;
        logic             t_minus;
        logic             t_ovf;
        logic             t_iosgn;
        logic [SEL_W-1:0] sw_sel;
        logic [SEL_W-1:0] flg_sel;
    } skip_fields_t;

endpackage

// File: rtl/skip_instr_decode.sv
// Module: splits an instruction word into the skip-group fields.
// Assumes the layout in skip_eval_pkg; the spare mask bit carries no test.
module skip_instr_decode
    import skip_eval_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    output skip_fields_t      fields
);

    logic unused_spare;

    // Field extraction and opcode match.
    always_comb begin
        fields.is_skip = (instr[OP_HI:OP_LO] == SKIP_OP);
        fields.invert  = instr[INV_BIT];
        fields.t_zero  = instr[ZERO_BIT];
        fields.t_plus  = instr[PLUS_BIT];
        fields.t_minus = instr[MINUS_BIT];
        fields.t_ovf   = instr[OVF_BIT];
        fields.t_iosgn = instr[IOSGN_BIT];
        fields.sw_sel  = instr[SW_LO +: SEL_W];
        fields.flg_sel = instr[FLG_LO +: SEL_W];
    end

    assign unused_spare = instr[SPARE_BIT];

endmodule

// File: rtl/skip_word_test.sv
// Module: zero and sign tests on one ones'-complement word.
// Assumes the sign is the top bit; only the all-zeros pattern is zero.
module skip_word_test #(
    parameter int W = 18
) (
    input  logic [W-1:0] word,
    output logic         is_zero,
    output logic         is_plus,
    output logic         is_minus
);

    // Zero detect and sign split.
    always_comb begin
        is_zero  = (word == '0);
        is_minus = word[W-1];
        is_plus  = ~word[W-1];
    end

endmodule

// File: rtl/skip_group_test.sv
// Module: numbered test over a bank of lines (switches or flags).
// Selector 1..N tests line N-1 for zero; all-ones selector tests every line
// for zero; 0 or an unmatched code gives no condition.
// Assumes N_LINES < 2**SEL_W - 1 so the all-ones code is free.
module skip_group_test #(
    parameter int N_LINES = 6,
    parameter int SEL_W   = 3
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [N_LINES-1:0] lines,
    output logic               cond
);

    localparam logic [SEL_W-1:0] ALL_CODE = '1;

    logic [N_LINES-1:0] hit;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        // Single-line match for selector value i+1.
        assign hit[i] = (sel == SEL_W'(i + 1)) && !lines[i];
    end

    // Combine single-line hits with the all-lines test.
    always_comb begin
        cond = (|hit) || ((sel == ALL_CODE) && (lines == '0));
    end

endmodule

// File: rtl/skip_eval.sv
// Module: skip-group evaluator top. Decodes the instruction, evaluates all
// selected conditions, ORs them, applies the invert bit and registers the
// skip request plus the overflow-clear strobe. Assumes inputs are stable at
// the rising edge; synchronous active-low reset.
module skip_eval
    import skip_eval_pkg::*;
#(
    parameter int NUM_SW  = 6,
    parameter int NUM_FLG = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] io_reg,
    input  logic              ovf,
    input  logic [NUM_SW-1:0] sense_sw,
    input  logic [NUM_FLG-1:0] prog_flag,
    output logic              skip_req,
    output logic              ovf_clear
);

    skip_fields_t f;
    logic ac_zero, ac_plus, ac_minus;
    logic io_zero_unused, io_plus, io_minus_unused;
    logic sw_cond, flg_cond;
    logic any_cond, decision;

    skip_instr_decode u_dec (
        .instr  (instr),
        .fields (f)
    );

    skip_word_test #(.W(WORD_W)) u_ac (
        .word     (acc),
        .is_zero  (ac_zero),
        .is_plus  (ac_plus),
        .is_minus (ac_minus)
    );

    skip_word_test #(.W(WORD_W)) u_io (
        .word     (io_reg),
        .is_zero  (io_zero_unused),
        .is_plus  (io_plus),
        .is_minus (io_minus_unused)
    );

    skip_group_test #(.N_LINES(NUM_SW), .SEL_W(SEL_W)) u_sw (
        .sel   (f.sw_sel),
        .lines (sense_sw),
        .cond  (sw_cond)
    );

    skip_group_test #(.N_LINES(NUM_FLG), .SEL_W(SEL_W)) u_flg (
        .sel   (f.flg_sel),
        .lines (prog_flag),
        .cond  (flg_cond)
    );

    // OR of every selected condition, then the invert.
    always_comb begin
        any_cond = (f.t_zero  && ac_zero)  ||
                   (f.t_plus  && ac_plus)  ||
                   (f.t_minus && ac_minus) ||
                   (f.t_ovf   && !ovf)     ||
                   (f.t_iosgn && io_plus)  ||
                   sw_cond || flg_cond;
        decision = any_cond ^ f.invert;
    end

    // Output register: one decision per clock, gated by the opcode match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_req  <= 1'b0;
            ovf_clear <= 1'b0;
        end else begin
            skip_req  <= f.is_skip && decision;
            ovf_clear <= f.is_skip && f.t_ovf;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> (!skip_req && !ovf_clear));

    p_nonskip_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(f.is_skip) |-> (!skip_req && !ovf_clear));

    p_minus_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && f.is_skip && !f.invert && instr[10:0] == 11'o0100 && acc == '1)
        |-> !skip_req);

    p_ovf_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && f.is_skip && f.t_ovf) |-> ovf_clear);

    p_empty_invert_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && f.is_skip && f.invert && instr[10:0] == 11'o0) |-> skip_req);

endmodule

// File: tb/skip_eval_tb_top.sv
module skip_eval_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] instr = '0, acc = '0, io_reg = '0;
    logic        ovf = 1'b0;
    logic [5:0]  sense_sw = '0, prog_flag = '0;
    logic        skip_req, ovf_clear;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    skip_eval dut_i (
        .clk(clk), .rst_n(rst_n), .instr(instr), .acc(acc), .io_reg(io_reg),
        .ovf(ovf), .sense_sw(sense_sw), .prog_flag(prog_flag),
        .skip_req(skip_req), .ovf_clear(ovf_clear)
    );

    typedef struct packed {
        logic [17:0] instr;
        logic [17:0] acc;
        logic [17:0] io;
        logic        ovf;
        logic [5:0]  sw;
        logic [5:0]  flg;
        logic        skip;
        logic        clr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{18'o640100, 18'o000000, 18'o0, 1'b0, 6'o00, 6'o00, 1'b1, 1'b0, 4'd4},  // R4 zero
        '{18'o640100, 18'o777777, 18'o0, 1'b0, 6'o00, 6'o00, 1'b0, 1'b0, 4'd4},  // R4 minus zero
        '{18'o640100, 18'o000005, 18'o0, 1'b0, 6'o00, 6'o00, 1'b0, 1'b0, 4'd4},  // R4 nonzero
        '{18'o650100, 18'o000005, 18'o0, 1'b0, 6'o00, 6'o00, 1'b1, 1'b0, 4'd10}, // R10 invert
        '{18'o640200, 18'o000001, 18'o0, 1'b0, 6'o00, 6'o00, 1'b1, 1'b0, 4'd5},  // R5 plus
        '{18'o640200, 18'o400000, 18'o0, 1'b0, 6'o00, 6'o00, 1'b0, 1'b0, 4'd5},
        '{18'o640400, 18'o400000, 18'o0, 1'b0, 6'o00, 6'o00, 1'b1, 1'b0, 4'd5},  // R5 minus
        '{18'o640400, 18'o377777, 18'o0, 1'b0, 6'o00, 6'o00, 1'b0, 1'b0, 4'd5},
        '{18'o641000, 18'o000000, 18'o0, 1'b0, 6'o00, 6'o00, 1'b1, 1'b1, 4'd6},  // R6
        '{18'o641000, 18'o000000, 18'o0, 1'b1, 6'o00, 6'o00, 1'b0, 1'b1, 4'd6},
        '{18'o651000, 18'o000000, 18'o0, 1'b1, 6'o00, 6'o00, 1'b1, 1'b1, 4'd6},
        '{18'o641100, 18'o000005, 18'o0, 1'b0, 6'o00, 6'o00, 1'b1, 1'b1, 4'd10}, // R10 OR
        '{18'o642000, 18'o0, 18'o000000, 1'b0, 6'o00, 6'o00, 1'b1, 1'b0, 4'd7},  // R7
        '{18'o642000, 18'o0, 18'o400000, 1'b0, 6'o00, 6'o00, 1'b0, 1'b0, 4'd7},
        '{18'o640030, 18'o5, 18'o0, 1'b0, 6'b000100, 6'o00, 1'b0, 1'b0, 4'd8},   // R8 sw3 set
        '{18'o640030, 18'o5, 18'o0, 1'b0, 6'b111011, 6'o00, 1'b1, 1'b0, 4'd8},   // R8 sw3 clear
        '{18'o640060, 18'o5, 18'o0, 1'b0, 6'b011111, 6'o00, 1'b1, 1'b0, 4'd8},   // R8 top switch
        '{18'o640070, 18'o5, 18'o0, 1'b0, 6'b000000, 6'o00, 1'b1, 1'b0, 4'd8},   // R8 all
        '{18'o640070, 18'o5, 18'o0, 1'b0, 6'b100000, 6'o00, 1'b0, 1'b0, 4'd8},
        '{18'o640000, 18'o5, 18'o0, 1'b0, 6'b000000, 6'o77, 1'b0, 1'b0, 4'd8},   // R8 no test
        '{18'o650000, 18'o5, 18'o0, 1'b0, 6'b111111, 6'o77, 1'b1, 1'b0, 4'd10},  // R10 empty invert
        '{18'o640003, 18'o5, 18'o0, 1'b0, 6'o00, 6'b000100, 1'b0, 1'b0, 4'd9},   // R9 flag3 set
        '{18'o640001, 18'o5, 18'o0, 1'b0, 6'o00, 6'b111110, 1'b1, 1'b0, 4'd9},   // R9 flag1 clear
        '{18'o640007, 18'o5, 18'o0, 1'b0, 6'o00, 6'b000000, 1'b1, 1'b0, 4'd9},   // R9 all
        '{18'o650007, 18'o5, 18'o0, 1'b0, 6'o00, 6'b000001, 1'b1, 1'b0, 4'd9},
        '{18'o640600, 18'o000000, 18'o0, 1'b0, 6'o00, 6'o00, 1'b1, 1'b0, 4'd10},
        '{18'o640500, 18'o400000, 18'o0, 1'b0, 6'o00, 6'o00, 1'b1, 1'b0, 4'd10},
        '{18'o650500, 18'o400000, 18'o0, 1'b0, 6'o00, 6'o00, 1'b0, 1'b0, 4'd10},
        '{18'o600000, 18'o000000, 18'o0, 1'b0, 6'o00, 6'o00, 1'b0, 1'b0, 4'd2},  // R2 jump
        '{18'o661100, 18'o000000, 18'o0, 1'b0, 6'o00, 6'o00, 1'b0, 1'b0, 4'd2}   // R2 opcode 66
    };

    task automatic apply(input vec_t v);
        instr = v.instr; acc = v.acc; io_reg = v.io; ovf = v.ovf;
        sense_sw = v.sw; prog_flag = v.flg;
    endtask

    task automatic check(input logic es, input logic ec, input int req, input int id);
        checks++;
        if (skip_req !== es || ovf_clear !== ec) begin
            errors++;
            $display("FAIL R%0d case %0d: skip_req=%0b ovf_clear=%0b expected %0b %0b",
                     req, id, skip_req, ovf_clear, es, ec);
        end
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset holds outputs low even with a skip-true instruction present.
        @(negedge clk);
        apply(VECS[8]);
        repeat (3) @(posedge clk);
        #5 check(1'b0, 1'b0, 1, 100);
        @(negedge clk) rst_n = 1'b1;

        // Table walk, one instruction per clock: R2 R4 R5 R6 R7 R8 R9 R10.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk) apply(VECS[i]);
            @(posedge clk);
            #5 check(VECS[i].skip, VECS[i].clr, int'(VECS[i].req), i);
        end

        // R3: input change after the edge does not reach the outputs.
        @(negedge clk) apply(VECS[8]);
        @(posedge clk);
        #2 apply(VECS[1]);
        #3 check(1'b1, 1'b1, 3, 101);
        @(posedge clk);
        #5 check(1'b0, 1'b0, 3, 102);

        // R1: reset asserted mid-run clears the registered outputs.
        @(negedge clk) begin apply(VECS[10]); rst_n = 1'b0; end
        @(posedge clk);
        #5 check(1'b0, 1'b0, 1, 103);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #5 check(1'b1, 1'b1, 6, 104);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule